// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This unit selects the smaller or the larger of two IEEE-754 binary floating-point operands. It handles both single precision (32-bit) and double precision (64-bit) values. A precision select and an operation select choose the mode for each operand pair. The comparison is exact, so the block has no rounding logic.

The unit takes one operand pair per cycle on a plain valid strobe. The result and an invalid-operation flag appear, registered, one clock later. Quiet NaN inputs are treated as missing data. If one operand is a NaN, the other operand is returned. If both are NaNs, an all-ones canonical NaN is returned. The invalid flag is raised only when a signalling NaN takes part.

Non-NaN values are ordered with a single unsigned comparison. Each sign-magnitude encoding is first mapped to a monotonic key. As a result, infinities, denormals and the two zeros need no special cases.

Top module: `fp_minmax_unit`

## Requirements
- R1: After reset `res` is 0, `inv_flag` is 0 and `out_vld` is 0. `out_vld` equals `in_vld` from the previous clock, and `res`/`inv_flag` belong to the pair presented with that strobe.
- R2: When `dbl_sel` is 0, only bits [31:0] of each operand are used, and `res[63:31+1]` is zero. When `dbl_sel` is 1, all 64 bits are used.
- R3: An operand is a NaN when its exponent field is all ones (bits [30:23] single, [62:52] double) and its fraction is non-zero. A NaN is quiet when the fraction MSB (bit 22 single, bit 51 double) is 1, and signalling when it is 0.
- R4: When exactly one operand is a quiet NaN, the result is the other operand and `inv_flag` is 0.
- R5: When exactly one operand is a signalling NaN, the result is the other operand and `inv_flag` is 1.
- R6: When both operands are NaNs, the result is the canonical NaN: 0x00000000_FFFFFFFF in single mode and 0xFFFFFFFF_FFFFFFFF in double mode.
- R7: When both operands are NaNs, `inv_flag` is 1 if either is signalling and 0 if both are quiet.
- R8: For two non-NaN operands, `max_sel`=0 returns the numerically smaller operand and `max_sel`=1 the larger. This includes infinities, denormals and mixed signs, and `inv_flag` is 0.
- R9: -0.0 orders below +0.0. For a pair of zeros with opposite signs, min returns -0.0 and max returns +0.0.
- R10: In a cycle with `in_vld` low, `res` and `inv_flag` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 64 | First operand (low 32 bits in single mode) |
| op_b | input | 64 | Second operand (low 32 bits in single mode) |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision |
| max_sel | input | 1 | 1 = maximum, 0 = minimum |
| in_vld | input | 1 | Operand pair valid |
| res | output | 64 | Selected value or canonical NaN |
| inv_flag | output | 1 | Invalid operation (signalling NaN seen) |
| out_vld | output | 1 | Result valid |

## Verification
Every result, flag and valid strobe is due exactly one clock after the edge that samples `in_vld`. The bench drives each pair at a falling edge and checks the outputs at the next falling edge, so exactly one rising edge separates stimulus from check. After every captured pair, an idle cycle with changed operands is checked the same way, one edge later, to show that the registers held. In single mode the operands' upper halves carry junk, and the result's upper half is checked to be zero.

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic        dbl_sel,
  input  logic        max_sel,
  input  logic        in_vld,
  output logic [63:0] res,
  output logic        inv_flag,
  output logic        out_vld
);

  logic        nan_a, nan_b, qbit_a, qbit_b, snan_a, snan_b;
  logic [63:0] a_w, b_w, key_a, key_b, cmp_res, nxt_res, canon;
  logic        pick_a;

  assign a_w = dbl_sel ? op_a : {32'h0, op_a[31:0]};
  assign b_w = dbl_sel ? op_b : {32'h0, op_b[31:0]};

  assign nan_a = dbl_sel ? (&op_a[62:52] && |op_a[51:0]) : (&op_a[30:23] && |op_a[22:0]);
  assign nan_b = dbl_sel ? (&op_b[62:52] && |op_b[51:0]) : (&op_b[30:23] && |op_b[22:0]);
  assign qbit_a = dbl_sel ? op_a[51] : op_a[22];
  assign qbit_b = dbl_sel ? op_b[51] : op_b[22];
  assign snan_a = nan_a && !qbit_a;
  assign snan_b = nan_b && !qbit_b;

  // monotonic key: negatives inverted, positives get the top bit set
  assign key_a = dbl_sel ? (op_a[63] ? ~op_a : {1'b1, op_a[62:0]})
                         : {32'h0, (op_a[31] ? ~op_a[31:0] : {1'b1, op_a[30:0]})};
  assign key_b = dbl_sel ? (op_b[63] ? ~op_b : {1'b1, op_b[62:0]})
                         : {32'h0, (op_b[31] ? ~op_b[31:0] : {1'b1, op_b[30:0]})};

  assign pick_a  = max_sel ? (key_a > key_b) : (key_a < key_b);
  assign cmp_res = pick_a ? a_w : b_w;
  assign canon   = dbl_sel ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;

  always_comb begin
    if (nan_a && nan_b) nxt_res = canon;
    else if (nan_a)     nxt_res = b_w;
    else if (nan_b)     nxt_res = a_w;
    else                nxt_res = cmp_res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res      <= '0;
      inv_flag <= 1'b0;
      out_vld  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        res      <= nxt_res;
        inv_flag <= snan_a || snan_b;
      end
    end
  end

  AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld)) else $error("AST_VLD_DELAY"); // R1

  AST_SP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !dbl_sel |=> res[63:32] == 32'h0) else $error("AST_SP_UPPER_ZERO"); // R2

  AST_ONE_NAN_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && nan_a && !nan_b |=> res == $past(b_w)) else $error("AST_ONE_NAN_OTHER"); // R4

  AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && (snan_a || snan_b) |=> inv_flag) else $error("AST_SNAN_FLAG"); // R5

  AST_CANON_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && nan_a && nan_b |=> (&res[31:0]) && (res[63:32] == ($past(dbl_sel) ? 32'hFFFF_FFFF : 32'h0)))
    else $error("AST_CANON_NAN"); // R6

  AST_QNAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !snan_a && !snan_b |=> !inv_flag) else $error("AST_QNAN_QUIET"); // R7

  AST_PICK_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !nan_a && !nan_b |=> (res == $past(a_w)) || (res == $past(b_w)))
    else $error("AST_PICK_OPERAND"); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld && out_vld |=> $stable(res) && $stable(inv_flag)) else $error("AST_IDLE_HOLD"); // R10

endmodule

// File: tb/test_fp_minmax_unit.sv
module test_fp_minmax_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        dbl_sel = 1'b0, max_sel = 1'b0, in_vld = 1'b0;
  logic [63:0] res;
  logic        inv_flag, out_vld;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  localparam int NORD = 11;
  localparam int NVAL = 15;

  always #10 clk = ~clk;

  fp_minmax_unit i_fp_minmax_unit (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .dbl_sel(dbl_sel),
    .max_sel(max_sel), .in_vld(in_vld), .res(res), .inv_flag(inv_flag), .out_vld(out_vld)
  );

  // indices 0..10 ascending order; 11,12 quiet NaNs; 13,14 signalling NaNs (R3)
  function automatic logic [31:0] spv(int k);
    case (k)
      0: return 32'hFF800000;  1: return 32'hC0000000;  2: return 32'hBF800000;
      3: return 32'h80000001;  4: return 32'h80000000;  5: return 32'h00000000;
      6: return 32'h00000001;  7: return 32'h007FFFFF;  8: return 32'h3F800000;
      9: return 32'h7F7FFFFF; 10: return 32'h7F800000; 11: return 32'h7FC00000;
     12: return 32'hFFC00001; 13: return 32'h7F800001; default: return 32'hFFA00000;
    endcase
  endfunction

  function automatic logic [63:0] dpv(int k);
    case (k)
      0: return 64'hFFF0000000000000;  1: return 64'hC000000000000000;
      2: return 64'hBFF0000000000000;  3: return 64'h8000000000000001;
      4: return 64'h8000000000000000;  5: return 64'h0000000000000000;
      6: return 64'h0000000000000001;  7: return 64'h000FFFFFFFFFFFFF;
      8: return 64'h3FF0000000000000;  9: return 64'h7FEFFFFFFFFFFFFF;
     10: return 64'h7FF0000000000000; 11: return 64'h7FF8000000000000;
     12: return 64'hFFF8000000000001; 13: return 64'h7FF0000000000001;
      default: return 64'hFFF4000000000000;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(res == 64'h0 && !inv_flag && !out_vld, "R1 reset", {res[63:2], inv_flag, out_vld}, 64'h0);
    rst_n = 1'b1;
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 2; m++) begin
        for (int i = 0; i < NVAL; i++) begin
          for (int j = 0; j < NVAL; j++) begin
            logic [63:0] va, vb, ea, eb, er, held;
            bit na, nb, sa, sb, ef;
            string rq;
            va = d ? dpv(i) : {32'hDEADBEEF, spv(i)};
            vb = d ? dpv(j) : {32'h5A5A5A5A, spv(j)};
            ea = d ? va : {32'h0, va[31:0]};
            eb = d ? vb : {32'h0, vb[31:0]};
            na = i >= NORD; nb = j >= NORD;
            sa = i >= 13;   sb = j >= 13;
            if (na && nb) begin
              er = d ? 64'hFFFFFFFFFFFFFFFF : 64'h00000000FFFFFFFF;
              ef = sa || sb; rq = (sa || sb) ? "R6/R7 snan pair" : "R6/R7 qnan pair";
            end else if (na || nb) begin
              er = na ? eb : ea; ef = sa || sb;
              rq = (sa || sb) ? "R5 one snan" : "R4 one qnan";
            end else begin
              er = (m ? (i > j) : (i < j)) ? ea : eb; ef = 1'b0;
              rq = ((i == 4 && j == 5) || (i == 5 && j == 4)) ? "R9 signed zero" : "R8 order";
            end
            if (!d) rq = {rq, " R2 single"};
            @(negedge clk);
            op_a = va; op_b = vb; dbl_sel = d[0]; max_sel = m[0]; in_vld = 1'b1;
            @(negedge clk);
            chk(res == er, rq, res, er);
            chk(inv_flag == ef && out_vld, {rq, " flag R1"}, {62'h0, inv_flag, out_vld}, {62'h0, ef, 1'b1});
            held = res;
            op_a = dpv((i + 3) % NVAL); op_b = ~va; in_vld = 1'b0;
            @(negedge clk);
            chk(res == held && inv_flag == ef && !out_vld, "R10 idle hold", res, held);
          end
        end
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule